// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a down-counting watchdog. A prescaler divides the peripheral clock into a count clock. The counter then runs from one less than a selectable period down to zero. Software has to refresh the watchdog before the counter passes zero. It may refresh only while the elapsed part of the period lies in a quarter that a 4-bit window mask permits. A refresh that is too early or too late is reported as an error, in the same way as an underflow.

Each of the two events, underflow and refresh error, does three things. It sets its own sticky flag. It emits a one-cycle request pulse, routed either to an interrupt output or to a reset-request output. It restarts the counter. The current count is visible at all times. An external sleep input can freeze the count unless configuration allows counting during sleep.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status signal, sampled or updated on each rising clock edge.

Top module: `window_watchdog`

## Requirements
- R1: `period_sel` picks the period P: code 0 is 256, 1 is 4096, 2 is 16384 and 3 is 65536. Each reload sets `count` to P-1.
- R2: `div_sel` picks the count-clock ratio D = 2^code for codes 2 to 13. The listed ratios are code 2 = /4, 6 = /64, 7 = /128, 8 = /256, 9 = /512, 10 = /1024, 11 = /2048 and 13 = /8192. Any other code gives /4. After a reload, `count` equals P-1-floor(k/D) after k further clock edges.
- R3: While `rst_n` is low, `count` is 0 and both flags and both request outputs are 0. On the first edge after release, `count` loads P-1.
- R4: On a count-clock tick with `count` at 0, the counter reloads to P-1 and `flag_underflow` sets. The selected request output pulses high for one cycle after that same edge.
- R5: The elapsed value is P-1-`count`. Window bit i permits refresh while the elapsed value lies in [i*P/4, (i+1)*P/4). The mask may be non-contiguous.
- R6: A refresh in a permitted quarter reloads `count` to P-1 and restarts the prescaler. It sets no flag and emits no request.
- R7: A refresh outside the permitted quarters sets `flag_refresh_err` and pulses the selected request for one cycle. It also reloads `count` to P-1.
- R8: A window mask of 4'b0000 or 4'b1111 permits refresh at any elapsed value.
- R9: `req_is_reset` = 0 routes event pulses to `irq`. `req_is_reset` = 1 routes them to `reset_req`. The two outputs are never high together.
- R10: The flags stay set until their own clear strobe is applied. Each clear affects only its own flag. A flag set by an event wins over a clear in the same cycle.
- R11: While `sleep` is high and `run_in_sleep` is 0, the counter and the prescaler hold their values. With `run_in_sleep` = 1, counting continues during sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 2 | Period code (R1) |
| div_sel | input | 4 | Prescaler ratio code (R2) |
| window_mask | input | 4 | One bit per quarter of the period that permits refresh |
| run_in_sleep | input | 1 | 1 keeps counting while sleep is high |
| req_is_reset | input | 1 | Event routing: 0 to interrupt, 1 to reset request |
| sleep | input | 1 | Sleep indication |
| refresh | input | 1 | One-cycle refresh strobe |
| clr_underflow | input | 1 | Clears the underflow flag |
| clr_refresh_err | input | 1 | Clears the refresh-error flag |
| count | output | 16 | Current counter value |
| flag_underflow | output | 1 | Sticky underflow flag |
| flag_refresh_err | output | 1 | Sticky refresh-error flag |
| irq | output | 1 | One-cycle interrupt request pulse |
| reset_req | output | 1 | One-cycle reset request pulse |

## Verification
A bad counter or prescaler state shows on `count` at once. A wrong ratio makes the value drift from P-1-floor(k/D) within D edges of a reload. A wrong quarter decode appears as a missing or spurious refresh-error flag and request pulse on the edge that consumes the refresh, so it is observable one cycle after the strobe. Freeze errors and underflow errors are seen through `count`: it either stops holding its value or fails to return to P-1 exactly P*D edges after a reload.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int CNT_W = 16;
  localparam int PRE_W = 13;

  // Largest count value for each period code
  function automatic logic [CNT_W-1:0] period_max(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(255);
      2'd1:    return CNT_W'(4095);
      2'd2:    return CNT_W'(16383);
      default: return CNT_W'(65535);
    endcase
  endfunction

  // Prescaler shift amount; unlisted codes fall back to divide-by-4
  function automatic logic [3:0] div_shift(input logic [3:0] code);
    if (code >= 4'd2 && code <= 4'd13) return code;
    return 4'd2;
  endfunction
endpackage

// File: rtl/wwd_prescale.sv
module wwd_prescale #(
  parameter int PRE_W = wwd_pkg::PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       clr,
  input  logic [3:0] shift,
  output logic       tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  assign mask = ~({PRE_W{1'b1}} << shift);
  assign tick = run_en && ((pre & mask) == mask) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre <= '0;
    else if (clr)    pre <= '0;
    else if (run_en) pre <= pre + 1'b1;
  end

  // R11
  frozen_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr) |=> (pre == $past(pre)));
endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
  parameter int CNT_W = wwd_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] pmax,
  output logic [CNT_W-1:0] count,
  output logic             loaded,
  output logic             unf
);
  assign unf = loaded && tick && !reload_req && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      loaded <= 1'b0;
    end else if (!loaded || reload_req) begin
      count  <= pmax;
      loaded <= 1'b1;
    end else if (tick) begin
      count <= (count == '0) ? pmax : count - 1'b1;
    end
  end

  // R4
  underflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> (count == $past(pmax)));
  // R6
  refresh_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> (count == $past(pmax)));
  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !run_en && !reload_req) |=> (count == $past(count)));
endmodule

// File: rtl/wwd_window.sv
module wwd_window #(
  parameter int CNT_W = wwd_pkg::CNT_W
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] pmax,
  input  logic [3:0]       window,
  output logic             allowed
);
  localparam int EW = CNT_W + 1;

  logic [EW-1:0] span, q1, q2, q3, elapsed;
  logic [1:0]    quarter;

  always_comb begin
    span    = {1'b0, pmax} + 1'b1;
    q1      = span >> 2;
    q2      = q1 << 1;
    q3      = q1 + q2;
    elapsed = {1'b0, pmax - count};
    if (elapsed >= q3)      quarter = 2'd3;
    else if (elapsed >= q2) quarter = 2'd2;
    else if (elapsed >= q1) quarter = 2'd1;
    else                    quarter = 2'd0;
    allowed = (window == 4'b0000) || window[quarter];
  end
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int CNT_W = wwd_pkg::CNT_W,
  parameter int PRE_W = wwd_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       period_sel,
  input  logic [3:0]       div_sel,
  input  logic [3:0]       window_mask,
  input  logic             run_in_sleep,
  input  logic             req_is_reset,
  input  logic             sleep,
  input  logic             refresh,
  input  logic             clr_underflow,
  input  logic             clr_refresh_err,
  output logic [CNT_W-1:0] count,
  output logic             flag_underflow,
  output logic             flag_refresh_err,
  output logic             irq,
  output logic             reset_req
);
  logic [CNT_W-1:0] pmax;
  logic             run_en, tick, loaded, unf, win_ok, rerr, evt;

  assign pmax   = CNT_W'(wwd_pkg::period_max(period_sel));
  assign run_en = !sleep || run_in_sleep;
  assign rerr   = refresh && !win_ok && loaded;
  assign evt    = unf || rerr;

  wwd_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .clr(refresh || !loaded), .shift(wwd_pkg::div_shift(div_sel)), .tick(tick)
  );

  wwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
    .reload_req(refresh), .pmax(pmax), .count(count),
    .loaded(loaded), .unf(unf)
  );

  wwd_window #(.CNT_W(CNT_W)) u_win (
    .count(count), .pmax(pmax), .window(window_mask), .allowed(win_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_underflow   <= 1'b0;
      flag_refresh_err <= 1'b0;
      irq              <= 1'b0;
      reset_req        <= 1'b0;
    end else begin
      flag_underflow   <= unf  || (flag_underflow && !clr_underflow);
      flag_refresh_err <= rerr || (flag_refresh_err && !clr_refresh_err);
      irq              <= evt && !req_is_reset;
      reset_req        <= evt && req_is_reset;
    end
  end

  // R7
  late_refresh_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && loaded && !win_ok) |=> flag_refresh_err);
  // R10
  rerr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_refresh_err) |-> $past(refresh));
  // R9
  pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || reset_req) |-> (flag_underflow || flag_refresh_err));
  // R9
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && reset_req));
endmodule

// File: tb/sim_window_watchdog.sv
module sim_window_watchdog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  period_sel;
  logic [3:0]  div_sel, window_mask;
  logic        run_in_sleep, req_is_reset, sleep, refresh;
  logic        clr_underflow, clr_refresh_err;
  logic [15:0] count;
  logic        flag_underflow, flag_refresh_err, irq, reset_req;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  window_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .div_sel(div_sel),
    .window_mask(window_mask), .run_in_sleep(run_in_sleep),
    .req_is_reset(req_is_reset), .sleep(sleep), .refresh(refresh),
    .clr_underflow(clr_underflow), .clr_refresh_err(clr_refresh_err),
    .count(count), .flag_underflow(flag_underflow),
    .flag_refresh_err(flag_refresh_err), .irq(irq), .reset_req(reset_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_refresh();
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
  endtask

  task automatic t_reset();
    check("R3 count in reset", count, 0);
    check("R3 flags in reset", {flag_underflow, flag_refresh_err}, 0);
    check("R3 requests in reset", {irq, reset_req}, 0);
    rst_n = 1'b1;
    edges(1);
    check("R3 load after release", count, 255);
  endtask

  task automatic t_rate();
    edges(40);
    check("R2 divide by 4", count, 245);
    div_sel = 4'd6;
    do_refresh();
    edges(202);
    check("R2 divide by 64", count, 252);
    div_sel = 4'd1;
    do_refresh();
    edges(40);
    check("R2 fallback code", count, 245);
    div_sel = 4'd2;
  endtask

  task automatic t_period();
    period_sel = 2'd1; do_refresh();
    check("R1 period 4096", count, 4095);
    period_sel = 2'd3; do_refresh();
    check("R1 period 65536", count, 65535);
    period_sel = 2'd2; do_refresh();
    check("R1 period 16384", count, 16383);
    period_sel = 2'd0; do_refresh();
    check("R1 period 256", count, 255);
  endtask

  task automatic t_underflow();
    req_is_reset = 1'b0;
    do_refresh();
    edges(1023);
    check("R4 count at zero", count, 0);
    check("R4 no early flag", flag_underflow, 0);
    edges(1);
    check("R4 underflow flag", flag_underflow, 1);
    check("R4 reload after underflow", count, 255);
    check("R9 interrupt pulse", {irq, reset_req}, 2'b10);
    edges(1);
    check("R4 pulse one cycle", irq, 0);
    check("R10 flag sticky", flag_underflow, 1);
    clr_refresh_err = 1'b1; edges(1); clr_refresh_err = 1'b0;
    check("R10 other clear ignored", flag_underflow, 1);
    clr_underflow = 1'b1; edges(1); clr_underflow = 1'b0;
    check("R10 flag cleared", flag_underflow, 0);
  endtask

  task automatic t_window();
    req_is_reset = 1'b1;
    window_mask = 4'b0000;
    do_refresh();
    window_mask = 4'b0101;
    edges(300);
    do_refresh();
    check("R7 error in quarter 1", flag_refresh_err, 1);
    check("R9 reset pulse", {irq, reset_req}, 2'b01);
    check("R7 reload on error", count, 255);
    edges(5);
    check("R10 error sticky", flag_refresh_err, 1);
    clr_refresh_err = 1'b1; edges(1); clr_refresh_err = 1'b0;
    check("R10 error cleared", flag_refresh_err, 0);
    edges(4);
    do_refresh();
    check("R6 quarter 0 accepted", {flag_refresh_err, reset_req}, 0);
    check("R6 reload", count, 255);
    edges(520);
    do_refresh();
    check("R5 quarter 2 accepted", {flag_refresh_err, reset_req}, 0);
    edges(800);
    do_refresh();
    check("R5 quarter 3 rejected", flag_refresh_err, 1);
    clr_refresh_err = 1'b1; edges(1); clr_refresh_err = 1'b0;
  endtask

  task automatic t_open_window();
    window_mask = 4'b1111;
    edges(900);
    do_refresh();
    check("R8 all ones late refresh", {flag_refresh_err, reset_req, irq}, 0);
    window_mask = 4'b0000;
    edges(900);
    do_refresh();
    check("R8 zero mask late refresh", {flag_refresh_err, reset_req, irq}, 0);
    check("R8 reload", count, 255);
  endtask

  task automatic t_sleep();
    run_in_sleep = 1'b0;
    do_refresh();
    sleep = 1'b1;
    edges(100);
    check("R11 frozen in sleep", count, 255);
    run_in_sleep = 1'b1;
    edges(40);
    check("R11 counts when allowed", count, 245);
    sleep = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; period_sel = 2'd0; div_sel = 4'd2; window_mask = 4'b0000;
    run_in_sleep = 1'b0; req_is_reset = 1'b0; sleep = 1'b0; refresh = 1'b0;
    clr_underflow = 1'b0; clr_refresh_err = 1'b0;
    edges(3);
    t_reset();
    t_rate();
    t_period();
    t_underflow();
    t_window();
    t_open_window();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule